// File: doc/BRIEF.md
# Epoch-Based Hybrid Cache Mode Selector

This block chooses, once per epoch, whether a hybrid last-level cache should run as a small fast cache or as a large slow cache. It watches the stream of L2 accesses, each marked hit or miss, and counts main-cache misses. An epoch ends when the miss count reaches a programmable length. At that point a cost model decides the mode for the next epoch. The cost model weighs the miss latency that would be saved against the extra hit latency that would be paid, plus a programmable switching penalty. All terms are compared as products of counts and latencies, so no divider is needed.

The cost of the mode not in use is estimated by a shadow tag store. This store is 2-way and uses LRU replacement. It sees only sampled sets: one set in 2^SAMPLE_B, taken where the low index bits are zero. In small mode the shadow store uses the large cache's set indexing and predicts how many misses the large cache would have. In large mode it uses the small cache's set indexing and predicts the small cache's misses. Its miss count is scaled up by the sampling ratio. The block outputs the current mode and a one-cycle strobe whenever the mode changes. Filling the main cache and carrying out the switch itself are left to neighbouring logic.

Top module: `cache_mode_picker`

## Requirements
- R1: After reset, `mode_large` is 0 (small mode) and `switch_stb` is 0.
- R2: The decision is evaluated only at an epoch end. An epoch ends on the access whose miss brings the epoch's miss count to `cfg_epoch_len`. Any resulting change appears on `mode_large` and `switch_stb` on the second rising edge after that access is sampled. There is never a change mid-epoch.
- R3: In small mode, let M be the epoch's main misses, E the shadow misses shifted left by SAMPLE_B, and H the epoch's main hits. The block switches to large mode when (M−E)·`cfg_mem_lat` > H·(`cfg_ht_large`−`cfg_ht_small`) + `cfg_switch_ovh`. If E ≥ M, the left-hand side counts as 0.
- R4: In large mode, the block switches to small mode when H·(`cfg_ht_large`−`cfg_ht_small`) > (E−M)·`cfg_mem_lat` + `cfg_switch_ovh`. If M ≥ E, the term (E−M) counts as 0.
- R5: The shadow store is probed only when the address bits [LINE_B+SAMPLE_B−1:LINE_B] are all zero. Its set index is taken from the address bits above those bits. It uses LARGE_IDX index bits in small mode and SMALL_IDX index bits in large mode. It holds full line addresses in 2 ways with LRU replacement, and it is cleared when the mode changes.
- R6: All epoch counters restart at each epoch end. Only an access arriving in the evaluation cycle itself is counted into the new epoch.
- R7: `switch_stb` is high for exactly one cycle, and only on an epoch end where the chosen mode differs from the previous one.
- R8: Both comparisons are strict. A large enough `cfg_switch_ovh` therefore prevents a switch that would otherwise occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | An L2 access is present this cycle |
| acc_hit | input | 1 | 1 = the main cache hit, 0 = the main cache missed |
| acc_addr | input | ADDR_W | Physical byte address of the access |
| cfg_epoch_len | input | CNT_W | Number of misses per epoch (must be at least 1) |
| cfg_mem_lat | input | LAT_W | Main memory access latency in cycles |
| cfg_ht_small | input | LAT_W | Hit latency in small mode |
| cfg_ht_large | input | LAT_W | Hit latency in large mode (must not be below `cfg_ht_small`) |
| cfg_switch_ovh | input | CNT_W+LAT_W | Fixed switching penalty added to the threshold |
| mode_large | output | 1 | Current mode: 1 = large, 0 = small |
| switch_stb | output | 1 | One-cycle pulse when the mode changes |

## Verification
The bench builds the block with ADDR_W=16, LINE_B=2, SMALL_IDX=3, LARGE_IDX=5, SAMPLE_B=1 and CNT_W=16. With these values the shadow store has 16 large-geometry sets and 4 small-geometry sets. Every other line is sampled, so a handful of addresses can make the shadow store hit, thrash, or ignore an access, and the expected cost terms are easy to work out by hand. An epoch length of 8 lets each scenario finish an epoch in a few dozen cycles. The scenarios cover a switch in each direction, a decision to stay put, an overhead that blocks a switch, and misses to unsampled lines that must not affect the estimate.

// File: rtl/cache_mode_picker.sv
module cache_mode_picker #(
  parameter int ADDR_W    = 32,
  parameter int LINE_B    = 6,
  parameter int SMALL_IDX = 10,
  parameter int LARGE_IDX = 14,
  parameter int SAMPLE_B  = 5,
  parameter int CNT_W     = 24,
  parameter int LAT_W     = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_vld,
  input  logic                   acc_hit,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic [CNT_W-1:0]       cfg_epoch_len,
  input  logic [LAT_W-1:0]       cfg_mem_lat,
  input  logic [LAT_W-1:0]       cfg_ht_small,
  input  logic [LAT_W-1:0]       cfg_ht_large,
  input  logic [CNT_W+LAT_W-1:0] cfg_switch_ovh,
  output logic                   mode_large,
  output logic                   switch_stb
);
  localparam int SH_W   = LARGE_IDX - SAMPLE_B;
  localparam int SETS   = 1 << SH_W;
  localparam int LA_W   = ADDR_W - LINE_B;
  localparam int EST_W  = CNT_W + SAMPLE_B;
  localparam int PROD_W = EST_W + LAT_W + 1;

  logic mode_q, stb_q, eval_q;
  logic [CNT_W-1:0] miss_q, hit_q, shm_q;

  logic [LA_W-1:0] tag_q [SETS][2];
  logic [1:0]      val_q [SETS];
  logic            lru_q [SETS];

  wire [LA_W-1:0] line    = acc_addr[ADDR_W-1:LINE_B];
  wire            sampled = acc_addr[LINE_B+SAMPLE_B-1:LINE_B] == '0;
  wire            probe   = acc_vld && sampled;

  logic [SH_W-1:0] sidx;
  always_comb begin
    if (mode_q) sidx = SH_W'(acc_addr[LINE_B+SMALL_IDX-1:LINE_B+SAMPLE_B]);
    else        sidx = acc_addr[LINE_B+LARGE_IDX-1:LINE_B+SAMPLE_B];
  end

  wire hit0   = val_q[sidx][0] && tag_q[sidx][0] == line;
  wire hit1   = val_q[sidx][1] && tag_q[sidx][1] == line;
  wire sh_hit = hit0 || hit1;

  // cost model, evaluated on epoch counts
  wire [EST_W-1:0]  est  = {shm_q, {SAMPLE_B{1'b0}}};
  wire [EST_W-1:0]  mext = EST_W'(miss_q);
  wire [LAT_W-1:0]  htd  = cfg_ht_large - cfg_ht_small;
  wire [PROD_W-1:0] cost = PROD_W'(hit_q) * PROD_W'(htd);
  wire [PROD_W-1:0] ovh  = PROD_W'(cfg_switch_ovh);
  wire [PROD_W-1:0] gain_l = (mext > est) ? PROD_W'(mext - est) * PROD_W'(cfg_mem_lat) : '0;
  wire [PROD_W-1:0] gain_s = (est > mext) ? PROD_W'(est - mext) * PROD_W'(cfg_mem_lat) : '0;
  wire go_large  = gain_l > cost + ovh;
  wire go_small  = cost > gain_s + ovh;
  wire next_mode = mode_q ? !go_small : go_large;
  wire change    = eval_q && (next_mode != mode_q);

  wire [CNT_W-1:0] miss_b = eval_q ? '0 : miss_q;
  wire [CNT_W-1:0] hit_b  = eval_q ? '0 : hit_q;
  wire [CNT_W-1:0] shm_b  = eval_q ? '0 : shm_q;
  wire is_miss = acc_vld && !acc_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      stb_q  <= 1'b0;
      eval_q <= 1'b0;
      miss_q <= '0;
      hit_q  <= '0;
      shm_q  <= '0;
    end else begin
      eval_q <= is_miss && (miss_b == cfg_epoch_len - 1'b1);
      miss_q <= miss_b + CNT_W'(is_miss);
      hit_q  <= hit_b + CNT_W'(acc_vld && acc_hit);
      shm_q  <= shm_b + CNT_W'(probe && !sh_hit);
      stb_q  <= change;
      if (eval_q) mode_q <= next_mode;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || change) begin
      for (int s = 0; s < SETS; s++) begin
        val_q[s] <= '0;
        lru_q[s] <= 1'b0;
      end
    end else if (probe) begin
      if (hit0)      lru_q[sidx] <= 1'b1;
      else if (hit1) lru_q[sidx] <= 1'b0;
      else begin
        val_q[sidx][lru_q[sidx]] <= 1'b1;
        lru_q[sidx] <= ~lru_q[sidx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (probe && !sh_hit) tag_q[sidx][lru_q[sidx]] <= line;
  end

  assign mode_large = mode_q;
  assign switch_stb = stb_q;

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    switch_stb |=> !switch_stb); // R7
  AST_STB_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    switch_stb |-> mode_large != $past(mode_large)); // R7
  AST_MODE_AT_EPOCH: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_q |=> $stable(mode_large)); // R2
  AST_SHADOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, shm_q} <= {1'b0, miss_q} + {1'b0, hit_q})); // R5
  AST_EPOCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    eval_q |=> miss_q <= 1); // R6
endmodule

// File: tb/cache_mode_picker_tb.sv
`timescale 1ns/100ps
module cache_mode_picker_tb_top;
  localparam int ADDR_W = 16, CNT_W = 16, LAT_W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_vld = 1'b0, acc_hit = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [CNT_W-1:0] cfg_epoch_len = 16'd8;
  logic [LAT_W-1:0] cfg_mem_lat = 8'd100, cfg_ht_small = 8'd6, cfg_ht_large = 8'd28;
  logic [CNT_W+LAT_W-1:0] cfg_switch_ovh = 24'd50;
  logic mode_large, switch_stb;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cache_mode_picker #(.ADDR_W(ADDR_W), .LINE_B(2), .SMALL_IDX(3), .LARGE_IDX(5),
    .SAMPLE_B(1), .CNT_W(CNT_W), .LAT_W(LAT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_hit(acc_hit), .acc_addr(acc_addr),
    .cfg_epoch_len(cfg_epoch_len), .cfg_mem_lat(cfg_mem_lat), .cfg_ht_small(cfg_ht_small),
    .cfg_ht_large(cfg_ht_large), .cfg_switch_ovh(cfg_switch_ovh),
    .mode_large(mode_large), .switch_stb(switch_stb));

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic send(input logic [ADDR_W-1:0] a, input logic h);
    acc_vld = 1'b1; acc_hit = h; acc_addr = a;
    @(negedge clk);
    acc_vld = 1'b0;
  endtask

  // outcome of an epoch that ended on the last send
  task automatic expect_end(input logic mode_exp, input logic stb_exp, input string tag);
    @(negedge clk);
    check(switch_stb, stb_exp, {tag, " strobe at epoch end"});
    check(mode_large, mode_exp, {tag, " mode at epoch end"});
    @(negedge clk);
    check(switch_stb, 1'b0, {tag, " R7 strobe one cycle"});
  endtask

  task automatic t_reset();
    check(mode_large, 1'b0, "R1 reset mode");
    check(switch_stb, 1'b0, "R1 reset strobe");
  endtask

  task automatic t_go_large();
    for (int i = 0; i < 8; i++) send((i % 2) ? 16'h0008 : 16'h0000, 1'b0);
    expect_end(1'b1, 1'b1, "R3 R6 small to large");
  endtask

  task automatic t_stay_large();
    for (int i = 0; i < 8; i++) send(16'((i % 3) * 16'h0020), 1'b0);
    expect_end(1'b1, 1'b0, "R4 R5 stay large under small-set thrash");
  endtask

  task automatic t_go_small();
    for (int i = 0; i < 20; i++) send(16'h0004, 1'b1);
    for (int i = 0; i < 8; i++) send((i % 2) ? 16'h0008 : 16'h0000, 1'b0);
    expect_end(1'b0, 1'b1, "R4 large to small");
  endtask

  task automatic t_epoch_edge();
    for (int i = 0; i < 7; i++) send((i % 2) ? 16'h0008 : 16'h0000, 1'b0);
    repeat (3) @(negedge clk);
    check(mode_large, 1'b0, "R2 no change before epoch end");
    check(switch_stb, 1'b0, "R2 no strobe before epoch end");
    send(16'h0008, 1'b0);
    expect_end(1'b1, 1'b1, "R2 change at epoch end");
  endtask

  task automatic t_overhead();
    cfg_switch_ovh = 24'd1000;
    for (int i = 0; i < 20; i++) send(16'h0004, 1'b1);
    for (int i = 0; i < 8; i++) send((i % 2) ? 16'h0008 : 16'h0000, 1'b0);
    expect_end(1'b1, 1'b0, "R8 overhead blocks switch");
    cfg_switch_ovh = 24'd50;
    for (int i = 0; i < 20; i++) send(16'h0004, 1'b1);
    for (int i = 0; i < 8; i++) send((i % 2) ? 16'h0008 : 16'h0000, 1'b0);
    expect_end(1'b0, 1'b1, "R8 lower overhead allows switch");
  endtask

  task automatic t_unsampled();
    for (int i = 0; i < 8; i++) send(16'(16'h0004 + i * 8), 1'b0);
    expect_end(1'b1, 1'b1, "R5 unsampled lines skip shadow");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_go_large();
    t_stay_large();
    t_go_small();
    t_epoch_edge();
    t_overhead();
    t_unsampled();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule